// File: doc/BRIEF.md
# Video Blanking Command Interleaver

This block sits between a video-mode line sequencer and the lane interface of a serial display link. The sequencer reports each blanking gap of the outgoing video stream as a level (`gap_active_i`) and a two-bit kind. The kinds are vertical blanking lines, the horizontal sync interval, the horizontal back porch and the horizontal front porch. The block registers the gap kind. From a per-kind configuration bit it then either requests a blanking long packet for the gap or drops the link to low-power state.

When a gap puts the link in low power, the block loads a window counter with that kind's programmed length in byte-clock cycles. While the window is open, it grants queued command packets access to the link. A packet is admitted only when its full cost fits in the cycles that remain. For high-speed packets the cost includes a fixed entry/exit overhead. High-speed and low-power command traffic have independent enable masks. A packet that has started is never cut short; the block waits for the serializer to report its end.

Top module: `blank_cmd_interleaver`

## Requirements
- R1: After reset, and until the first gap is registered, `gap_kind_o` is 0 (none) and `link_lp_o`, `blank_req_o` and `cmd_gnt_o` are all 0.
- R2: One clock after an edge at which `gap_active_i` is high, `gap_kind_o` shows the kind captured at that edge. Input codes 0/1/2/3 (vertical blanking, horizontal sync, back porch, front porch) map to output codes 1/2/3/4. When `gap_active_i` is low at an edge, the output returns to 0 after that edge.
- R3: During a gap of kind k, `link_lp_o` equals `lp_sel_i[k]` and `blank_req_o` equals its inverse. The two outputs are never high together.
- R4: The window length is taken from a different field for each kind: vertical blanking from `win_vb_i[15:0]`, back porch from `win_h_i[7:0]`, front porch from `win_h_i[15:8]` and horizontal sync from `win_h_i[23:16]`. With length N, the remaining count in the k-th cycle of the gap (k=0 first) is N-k, down to 0.
- R5: A command is granted only if its cost is at most the remaining count. The cost is `cmd_len_i + hs_ovh_i` for a high-speed command (`cmd_lp_i`=0) and `cmd_len_i` for a low-power command.
- R6: A window length of zero gives no grant for the whole gap, even with low-power state selected.
- R7: A gap whose selection bit requests a blanking packet gives no grant.
- R8: A high-speed command needs `hs_ilv_en_i[k]`=1 and a low-power command needs `lp_ilv_en_i[k]`=1, where k is the current gap kind.
- R9: After a grant, no further grant is given until `cmd_done_i` is seen. The packet in progress survives the end of the window or gap.
- R10: No grant is given once the remaining count has reached zero, nor outside a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gap_active_i | input | 1 | Sequencer is in a blanking gap |
| gap_kind_i | input | 2 | Gap kind: 0 vertical, 1 h-sync, 2 back porch, 3 front porch |
| lp_sel_i | input | 4 | Per-kind choice: 1 low-power state, 0 blanking packet |
| hs_ilv_en_i | input | 4 | Per-kind enable for high-speed commands |
| lp_ilv_en_i | input | 4 | Per-kind enable for low-power commands |
| win_vb_i | input | 16 | Vertical blanking window length |
| win_h_i | input | 24 | Horizontal window lengths: [7:0] back porch, [15:8] front porch, [23:16] sync |
| hs_ovh_i | input | 8 | High-speed entry/exit overhead in byte cycles |
| cmd_req_i | input | 1 | A command packet is waiting |
| cmd_len_i | input | 16 | Length of the waiting packet in byte cycles |
| cmd_lp_i | input | 1 | Waiting packet is low-power (1) or high-speed (0) |
| cmd_done_i | input | 1 | Serializer finished the granted packet |
| gap_kind_o | output | 3 | Registered gap kind, 0 when no gap |
| link_lp_o | output | 1 | Request for low-power link state |
| blank_req_o | output | 1 | Request for a blanking long packet |
| cmd_gnt_o | output | 1 | Grant pulse for the waiting packet |

## Verification
A wrong window counter shows up first at the admission boundary. A packet whose cost equals the remaining count gets refused, or one a cycle too large gets admitted. This is visible on `cmd_gnt_o` in the very cycle the request is presented. A stuck busy flag shows as a missing grant on the first request after `cmd_done_i`. A wrong field decode or kind register shows one cycle after the gap starts, on `gap_kind_o`, `link_lp_o` and `blank_req_o`, or as a wrong grant boundary for that kind.

// File: rtl/blank_ilv_pkg.sv
package blank_ilv_pkg;
  typedef enum logic [2:0] {
    GAP_NONE   = 3'd0,
    GAP_VBLANK = 3'd1,
    GAP_HSYNC  = 3'd2,
    GAP_HBACK  = 3'd3,
    GAP_HFRONT = 3'd4
  } gap_e;

  localparam int unsigned NUM_KINDS = 4;
  localparam int unsigned KIND_W    = 2;
endpackage

// File: rtl/gap_classifier.sv
module gap_classifier
  import blank_ilv_pkg::*;
#(
  parameter int unsigned VB_W = 16,
  parameter int unsigned H_W  = 8,
  localparam int unsigned CNT_W = (VB_W > H_W) ? VB_W : H_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  gap_active_i,
  input  logic [KIND_W-1:0]     gap_kind_i,
  input  logic [NUM_KINDS-1:0]  lp_sel_i,
  input  logic [VB_W-1:0]       win_vb_i,
  input  logic [3*H_W-1:0]      win_h_i,
  output gap_e                  kind_o,
  output logic [KIND_W-1:0]     idx_o,
  output logic                  link_lp_o,
  output logic                  blank_o,
  output logic                  load_o,
  output logic [CNT_W-1:0]      load_val_o
);
  // horizontal windows by kind index: sync, back porch, front porch
  logic [CNT_W-1:0] win_by_kind [NUM_KINDS];
  localparam int unsigned H_LANE [3] = '{2, 0, 1};

  assign win_by_kind[0] = CNT_W'(win_vb_i);
  for (genvar g = 1; g < NUM_KINDS; g++) begin : g_hwin
    assign win_by_kind[g] = CNT_W'(win_h_i[H_LANE[g-1]*H_W +: H_W]);
  end

  logic              act_q;
  logic [KIND_W-1:0] idx_q;
  logic              start;

  assign start      = gap_active_i && (!act_q || gap_kind_i != idx_q);
  assign load_o     = start;
  assign load_val_o = lp_sel_i[gap_kind_i] ? win_by_kind[gap_kind_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      idx_q     <= '0;
      kind_o    <= GAP_NONE;
      link_lp_o <= 1'b0;
      blank_o   <= 1'b0;
    end else begin
      act_q <= gap_active_i;
      if (gap_active_i) begin
        idx_q     <= gap_kind_i;
        kind_o    <= gap_e'({1'b0, gap_kind_i} + 3'd1);
        link_lp_o <= lp_sel_i[gap_kind_i];
        blank_o   <= !lp_sel_i[gap_kind_i];
      end else begin
        kind_o    <= GAP_NONE;
        link_lp_o <= 1'b0;
        blank_o   <= 1'b0;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (load_i)         cnt_o <= load_val_i;
    else if (clear_i)        cnt_o <= '0;
    else if (cnt_o != '0)    cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter
  import blank_ilv_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned OVH_W = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned COST_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_gap_i,
  input  logic                 link_lp_i,
  input  logic [KIND_W-1:0]    idx_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [NUM_KINDS-1:0] hs_en_i,
  input  logic [NUM_KINDS-1:0] lp_en_i,
  input  logic [OVH_W-1:0]     ovh_i,
  input  logic                 req_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 req_lp_i,
  input  logic                 done_i,
  output logic                 gnt_o
);
  logic              busy_q;
  logic              win_open;
  logic              kind_en;
  logic [COST_W-1:0] cost;

  assign win_open = in_gap_i && link_lp_i && (cnt_i != '0);
  assign kind_en  = req_lp_i ? lp_en_i[idx_i] : hs_en_i[idx_i];
  assign cost     = COST_W'(len_i) + (req_lp_i ? '0 : COST_W'(ovh_i));
  assign gnt_o    = win_open && kind_en && req_i && !busy_q &&
                    (cost <= COST_W'(cnt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (gnt_o)   busy_q <= 1'b1;
    else if (done_i)  busy_q <= 1'b0;
  end
endmodule

// File: rtl/blank_cmd_interleaver.sv
module blank_cmd_interleaver
  import blank_ilv_pkg::*;
#(
  parameter int unsigned VB_W  = 16,
  parameter int unsigned H_W   = 8,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned OVH_W = 8,
  localparam int unsigned CNT_W = (VB_W > H_W) ? VB_W : H_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 gap_active_i,
  input  logic [KIND_W-1:0]    gap_kind_i,
  input  logic [NUM_KINDS-1:0] lp_sel_i,
  input  logic [NUM_KINDS-1:0] hs_ilv_en_i,
  input  logic [NUM_KINDS-1:0] lp_ilv_en_i,
  input  logic [VB_W-1:0]      win_vb_i,
  input  logic [3*H_W-1:0]     win_h_i,
  input  logic [OVH_W-1:0]     hs_ovh_i,
  input  logic                 cmd_req_i,
  input  logic [LEN_W-1:0]     cmd_len_i,
  input  logic                 cmd_lp_i,
  input  logic                 cmd_done_i,
  output logic [2:0]           gap_kind_o,
  output logic                 link_lp_o,
  output logic                 blank_req_o,
  output logic                 cmd_gnt_o
);
  gap_e              kind;
  logic [KIND_W-1:0] idx;
  logic              lp_q;
  logic              blank_q;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  win_cnt;

  gap_classifier #(.VB_W(VB_W), .H_W(H_W)) u_cls (
    .clk_i, .rst_ni, .gap_active_i, .gap_kind_i, .lp_sel_i, .win_vb_i, .win_h_i,
    .kind_o(kind), .idx_o(idx), .link_lp_o(lp_q), .blank_o(blank_q),
    .load_o(load), .load_val_o(load_val)
  );

  win_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .clear_i(!gap_active_i), .cnt_o(win_cnt)
  );

  cmd_arbiter #(.LEN_W(LEN_W), .OVH_W(OVH_W), .CNT_W(CNT_W)) u_arb (
    .clk_i, .rst_ni, .in_gap_i(kind != GAP_NONE), .link_lp_i(lp_q), .idx_i(idx),
    .cnt_i(win_cnt), .hs_en_i(hs_ilv_en_i), .lp_en_i(lp_ilv_en_i), .ovh_i(hs_ovh_i),
    .req_i(cmd_req_i), .len_i(cmd_len_i), .req_lp_i(cmd_lp_i), .done_i(cmd_done_i),
    .gnt_o(cmd_gnt_o)
  );

  assign gap_kind_o  = kind;
  assign link_lp_o   = lp_q;
  assign blank_req_o = blank_q;
endmodule

// File: rtl/blank_cmd_interleaver_chk.sv
module blank_cmd_interleaver_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] gap_kind_o,
  input logic       link_lp_o,
  input logic       blank_req_o,
  input logic       cmd_gnt_o,
  input logic       cmd_req_i,
  input logic       cmd_done_i
);
  assert_lp_blank_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_lp_o && blank_req_o));

  assert_idle_no_link_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_kind_o == 3'd0) |-> (!link_lp_o && !blank_req_o));

  assert_gnt_only_lp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_gnt_o |-> link_lp_o);

  assert_no_gnt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_kind_o == 3'd0) |-> !cmd_gnt_o);

  assert_single_packet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_gnt_o |=> !cmd_gnt_o);

  assert_gnt_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_gnt_o |-> cmd_req_i);

  assert_kind_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_kind_o <= 3'd4);

  logic unused_done;
  assign unused_done = cmd_done_i;
endmodule

bind blank_cmd_interleaver blank_cmd_interleaver_chk u_chk (
  .clk_i, .rst_ni, .gap_kind_o, .link_lp_o, .blank_req_o, .cmd_gnt_o,
  .cmd_req_i, .cmd_done_i
);

// File: tb/tb_blank_cmd_interleaver.sv
module tb_blank_cmd_interleaver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gap_active = 1'b0;
  logic [1:0]  gap_kind = '0;
  logic [3:0]  lp_sel = '0;
  logic [3:0]  hs_en = '0;
  logic [3:0]  lp_en = '0;
  logic [15:0] win_vb = '0;
  logic [23:0] win_h = '0;
  logic [7:0]  ovh = '0;
  logic        cmd_req = 1'b0;
  logic [15:0] cmd_len = '0;
  logic        cmd_lp = 1'b0;
  logic        cmd_done = 1'b0;
  logic [2:0]  kind_o;
  logic        lp_o, blank_o, gnt_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blank_cmd_interleaver dut (
    .clk_i(clk), .rst_ni(rst_n), .gap_active_i(gap_active), .gap_kind_i(gap_kind),
    .lp_sel_i(lp_sel), .hs_ilv_en_i(hs_en), .lp_ilv_en_i(lp_en), .win_vb_i(win_vb),
    .win_h_i(win_h), .hs_ovh_i(ovh), .cmd_req_i(cmd_req), .cmd_len_i(cmd_len),
    .cmd_lp_i(cmd_lp), .cmd_done_i(cmd_done), .gap_kind_o(kind_o), .link_lp_o(lp_o),
    .blank_req_o(blank_o), .cmd_gnt_o(gnt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_gap();
    @(negedge clk);
    cmd_req = 1'b0; gap_active = 1'b0;
    @(negedge clk);
  endtask

  // Presents a request in cycle k of a fresh gap and checks the grant.
  task automatic try_grant(input logic [1:0] kind, input int k, input int len,
                           input logic lp, input logic exp, input string req);
    @(negedge clk);
    gap_active = 1'b1; gap_kind = kind; cmd_req = 1'b0;
    repeat (k + 1) @(negedge clk);
    cmd_req = 1'b1; cmd_len = 16'(len); cmd_lp = lp;
    #1 check(req, gnt_o, exp);
    @(negedge clk);
    cmd_req = 1'b0; gap_active = 1'b0;
    if (exp) begin
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 kind", kind_o, 0);
    check("R1 lp", lp_o, 0);
    check("R1 blank", blank_o, 0);
    check("R1 gnt", gnt_o, 0);
  endtask

  task automatic t_classify();
    lp_sel = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      gap_active = 1'b1; gap_kind = 2'(k);
      @(negedge clk);
      check("R2 kind code", kind_o, k + 1);
      check("R3 lp", lp_o, lp_sel[k]);
      check("R3 blank", blank_o, !lp_sel[k]);
    end
    @(negedge clk);
    gap_active = 1'b0;
    @(negedge clk);
    check("R2 back to none", kind_o, 0);
    check("R3 lp idle", lp_o, 0);
  endtask

  task automatic t_fields();
    lp_sel = 4'b1111; hs_en = 4'b1111; lp_en = 4'b0000; ovh = 8'd2;
    win_h = {8'd7, 8'd6, 8'd5}; win_vb = 16'd300;
    try_grant(2'd2, 0, 3, 1'b0, 1'b1, "R4 back porch fits");
    try_grant(2'd2, 0, 4, 1'b0, 1'b0, "R4 back porch too long");
    try_grant(2'd3, 0, 4, 1'b0, 1'b1, "R4 front porch fits");
    try_grant(2'd3, 0, 5, 1'b0, 1'b0, "R4 front porch too long");
    try_grant(2'd1, 0, 5, 1'b0, 1'b1, "R4 sync fits");
    try_grant(2'd1, 0, 6, 1'b0, 1'b0, "R4 sync too long");
    try_grant(2'd0, 0, 298, 1'b0, 1'b1, "R4 vblank fits");
    try_grant(2'd0, 0, 299, 1'b0, 1'b0, "R4 vblank too long");
  endtask

  task automatic t_countdown();
    // back porch N=5, cycle 2 leaves 3
    try_grant(2'd2, 2, 1, 1'b0, 1'b1, "R5 remaining equals cost");
    try_grant(2'd2, 2, 2, 1'b0, 1'b0, "R5 remaining below cost");
    try_grant(2'd2, 5, 0, 1'b1, 1'b0, "R10 count at zero");
  endtask

  task automatic t_lp_cmd();
    ovh = 8'd10;
    try_grant(2'd2, 0, 5, 1'b1, 1'b0, "R8 lp mask clear");
    lp_en = 4'b0100;
    try_grant(2'd2, 0, 5, 1'b1, 1'b1, "R5 lp cost excludes overhead");
    try_grant(2'd2, 0, 5, 1'b0, 1'b0, "R5 hs cost includes overhead");
    hs_en = 4'b1011; ovh = 8'd0;
    try_grant(2'd2, 0, 1, 1'b0, 1'b0, "R8 hs mask clear");
    hs_en = 4'b1111; lp_en = 4'b0000; ovh = 8'd2;
  endtask

  task automatic t_zero_and_blank();
    win_h = {8'd7, 8'd6, 8'd0};
    try_grant(2'd2, 0, 0, 1'b0, 1'b0, "R6 zero window");
    win_h = {8'd7, 8'd6, 8'd5};
    lp_sel = 4'b1011;
    try_grant(2'd2, 0, 1, 1'b0, 1'b0, "R7 blanking gap");
    lp_sel = 4'b1111;
  endtask

  task automatic t_busy();
    win_vb = 16'd50; ovh = 8'd0;
    @(negedge clk);
    gap_active = 1'b1; gap_kind = 2'd0;
    @(negedge clk);
    cmd_req = 1'b1; cmd_len = 16'd4; cmd_lp = 1'b0;
    #1 check("R9 first grant", gnt_o, 1);
    @(negedge clk);
    #1 check("R9 blocked while busy", gnt_o, 0);
    @(negedge clk);
    #1 check("R9 still blocked", gnt_o, 0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    #1 check("R9 grant after done", gnt_o, 1);
    @(negedge clk);
    cmd_req = 1'b0; gap_active = 1'b0;
    @(negedge clk);
    cmd_req = 1'b1; gap_active = 1'b0;
    #1 check("R10 no grant outside gap", gnt_o, 0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0; cmd_req = 1'b0;
    idle_gap();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    idle_gap();
    t_fields();
    t_countdown();
    t_lp_cmd();
    t_zero_and_blank();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule